// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

This block is one timer channel placed on a simple synchronous register bus. Software programs a start value and a control word. Each bus cycle carries a word offset, a write strobe and write data. Read data is a combinational function of the offset. An external tick-enable input is divided by 1, 16 or 256. Each divided tick lowers the count by one while the channel runs. When the count expires, the channel raises a raw interrupt flag. It then reloads according to the selected mode. A single interrupt output reflects the flag gated by an enable bit.

The channel is built around a three-state run machine. The states are:

- `ST_STOP`: the enable bit is clear and the count is frozen.
- `ST_COUNT`: the channel is counting.
- `ST_HOLD`: a one-shot has finished and the count is parked at zero.

The transitions are:

- **enable-off**: any state goes to `ST_STOP` when a control or load write leaves the enable bit clear.
- **arm**: `ST_STOP` or `ST_HOLD` goes to `ST_COUNT` when a control or load write leaves the channel enabled with a usable count.
- **shot-done**: `ST_COUNT` goes to `ST_HOLD` when a one-shot expires.
- **park**: any state goes to `ST_HOLD` when a write leaves the channel enabled in one-shot mode with a zero count.

The three reload behaviours are free-running wrap, periodic reload and one-shot stop. A background limit can be changed without touching the count that is running.

Top module: `countdown_timer`

## Requirements
- R1: After reset, the control word reads 0x20 (only the interrupt enable set). The count reads 0xFFFFFFFF. The raw flag reads 0 and the interrupt output is low.
- R2: A write to offset 0 sets both the limit and the count to the written value. Reads at offset 0 and offset 6 both return the limit.
- R3: A write to offset 6 changes the limit only. The running count is not changed.
- R4: Control bits 3:2 pick the divide ratio: 00 and 11 divide by 1, 01 by 16, 10 by 256. The prescaler restarts on every control or load write, so the first divided tick after such a write needs a full period of tick-enable pulses.
- R5: While control bit 7 (enable) is clear, tick-enable pulses leave the count unchanged.
- R6: In periodic mode (bit 6 set, bit 0 clear), a count of N expires on the Nth divided tick, with 0 and 1 both expiring on the first. The count then reloads from the limit.
- R7: In free-running mode (bits 6 and 0 clear), an expiry reloads the count with 0x0000FFFF when bit 1 is clear and 0xFFFFFFFF when bit 1 is set.
- R8: In one-shot mode (bit 0 set, taking priority over bit 6), an expiry leaves the count at 0, and no further expiries follow. Loading 0 in one-shot mode never expires.
- R9: With bit 1 clear (16-bit mode), only the low 16 bits decrement and are tested for expiry. The upper bits are kept until a reload, and every reload leaves them zero.
- R10: An expiry sets the raw flag, read at offset 4 bit 0. Offset 5 reads the raw flag ANDed with control bit 5. The interrupt output equals the offset 5 value.
- R11: Any write to offset 3 clears the raw flag. If an expiry falls in the same cycle, the flag stays set.
- R12: Writes to offset 1 (current count) have no effect. Offset 1 reads the live count, and offset 2 reads the 8-bit control word.
- R13: Offsets 3 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-rate enable pulse ahead of the prescaler |
| bus_addr | input | 3 | Word offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| irq | output | 1 | Masked interrupt request |

## Verification
Two functions can land in the same clock edge: a counter expiry, which sets the raw flag, and a write to the clear offset, which clears it. The bench provokes this by counting a periodic channel down to one. It then drives a tick-enable pulse and a clear-offset write in the same cycle. It judges the outcome by reading the raw flag, which must stay set, and the count, which must already show the reload value. A separate clear with no tick must then drop the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } run_state_e;

    typedef enum logic [2:0] {
        OFS_LOAD   = 3'd0,
        OFS_VALUE  = 3'd1,
        OFS_CTRL   = 3'd2,
        OFS_ICLR   = 3'd3,
        OFS_RAW    = 3'd4,
        OFS_MASKED = 3'd5,
        OFS_BGLOAD = 3'd6
    } reg_ofs_e;

    // Control word layout, bit 7 down to bit 0
    typedef struct packed {
        logic       enable;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] div_sel;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam int CTRL_W = 8;
    localparam ctrl_t CTRL_RESET = ctrl_t'(8'h20);

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] div_sel,
    output logic       step
);
    localparam int PRE_W = $clog2(DIV_HI);

    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] last_v;

    always_comb begin
        unique case (div_sel)
            2'b01:   last_v = PRE_W'(DIV_MID - 1);
            2'b10:   last_v = PRE_W'(DIV_HI - 1);
            default: last_v = '0;
        endcase
    end

    assign step = run && tick_en && !restart && (pcnt_q == last_v);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (restart || !run) begin
            pcnt_q <= '0;
        end else if (tick_en) begin
            pcnt_q <= (pcnt_q == last_v) ? '0 : pcnt_q + 1'b1;
        end
    end

    AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !step); // R5
    AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(restart) && (div_sel == 2'b01 || div_sel == 2'b10)) |-> !step); // R4

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load_wr,
    input  logic [DW-1:0] load_val,
    input  logic          ctrl_wr,
    input  logic          mode_en,
    input  logic          mode_oneshot,
    input  logic          mode_periodic,
    input  logic          mode_wide,
    input  logic          nxt_en,
    input  logic          nxt_oneshot,
    input  logic          nxt_wide,
    input  logic [DW-1:0] limit,
    output logic [DW-1:0] count,
    output logic          expire,
    output logic          running
);
    localparam int HALF = DW / 2;

    run_state_e    state_q, state_d;
    logic [DW-1:0] count_q;
    logic [DW-1:0] cur;
    logic [DW-1:0] reload_v;
    logic [DW-1:0] dec_v;
    logic          hit;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic wide);
        return wide ? v : {{(DW-HALF){1'b0}}, v[HALF-1:0]};
    endfunction

    function automatic run_state_e pick(input logic en, input logic shot,
                                        input logic [DW-1:0] v);
        if (!en)
            return ST_STOP;
        else if (shot && v == '0)
            return ST_HOLD;
        else
            return ST_COUNT;
    endfunction

    assign cur = fit(count_q, mode_wide);
    assign hit = step && (state_q == ST_COUNT) && (cur <= DW'(1));

    always_comb begin
        if (mode_oneshot)
            reload_v = '0;
        else if (mode_periodic)
            reload_v = fit(limit, mode_wide);
        else
            reload_v = fit('1, mode_wide);
    end

    always_comb begin
        if (mode_wide)
            dec_v = count_q - 1'b1;
        else
            dec_v = {count_q[DW-1:HALF], count_q[HALF-1:0] - 1'b1};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (load_wr) begin
            state_d = pick(mode_en, mode_oneshot, fit(load_val, mode_wide));
        end else if (ctrl_wr) begin
            state_d = pick(nxt_en, nxt_oneshot, fit(count_q, nxt_wide));
        end else begin
            unique case (state_q)
                ST_COUNT: if (hit && mode_oneshot) state_d = ST_HOLD;
                ST_STOP:  state_d = ST_STOP;
                ST_HOLD:  state_d = ST_HOLD;
                default:  state_d = ST_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_STOP;
        else
            state_q <= state_d;
    end

    // output / datapath register
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '1;
        else if (load_wr)
            count_q <= load_val;
        else if (hit)
            count_q <= reload_v;
        else if (step && state_q == ST_COUNT)
            count_q <= dec_v;
    end

    assign count   = count_q;
    assign expire  = hit;
    assign running = (state_q == ST_COUNT);

    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> count_q == $past(load_val)); // R2
    AST_STOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !load_wr) |=> $stable(count_q)); // R5
    AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_wr && state_q == ST_COUNT && cur > DW'(1))
        |=> count_q[HALF-1:0] == HALF'($past(count_q[HALF-1:0]) - 1'b1)); // R9
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> cur == '0); // R8
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !expire); // R8

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] count,
    input  logic          expire,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output ctrl_t         ctrl_q,
    output ctrl_t         ctrl_d,
    output logic          ctrl_wr,
    output logic          load_wr,
    output logic [DW-1:0] limit
);
    logic          bg_wr;
    logic          clr_wr;
    logic          raw_q;
    logic          masked;
    logic [DW-1:0] limit_q;

    assign load_wr = bus_we && (bus_addr == OFS_LOAD);
    assign ctrl_wr = bus_we && (bus_addr == OFS_CTRL);
    assign bg_wr   = bus_we && (bus_addr == OFS_BGLOAD);
    assign clr_wr  = bus_we && (bus_addr == OFS_ICLR);
    assign ctrl_d  = ctrl_t'(bus_wdata[CTRL_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            limit_q <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= ctrl_d;
            if (load_wr || bg_wr)
                limit_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else if (expire)
            raw_q <= 1'b1;
        else if (clr_wr)
            raw_q <= 1'b0;
    end

    assign masked = raw_q && ctrl_q.irq_en;
    assign irq    = masked;
    assign limit  = limit_q;

    always_comb begin
        case (bus_addr)
            OFS_LOAD, OFS_BGLOAD: bus_rdata = limit_q;
            OFS_VALUE:            bus_rdata = count;
            OFS_CTRL:             bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            OFS_RAW:              bus_rdata = {{(DW-1){1'b0}}, raw_q};
            OFS_MASKED:           bus_rdata = {{(DW-1){1'b0}}, masked};
            default:              bus_rdata = '0;
        endcase
    end

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_q); // R10
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expire) |=> !raw_q); // R11
    AST_BG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bg_wr |=> limit_q == $past(bus_wdata)); // R3

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
    import tmr_pkg::*;
#(
    parameter int DW      = 32,
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [2:0]    bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    ctrl_t         ctrl_q, ctrl_d;
    logic          ctrl_wr, load_wr;
    logic [DW-1:0] limit, count;
    logic          expire, running, step;

    tmr_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .count     (count),
        .expire    (expire),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .ctrl_q    (ctrl_q),
        .ctrl_d    (ctrl_d),
        .ctrl_wr   (ctrl_wr),
        .load_wr   (load_wr),
        .limit     (limit)
    );

    tmr_prescale #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (running),
        .restart (ctrl_wr || load_wr),
        .div_sel (ctrl_q.div_sel),
        .step    (step)
    );

    tmr_counter #(.DW(DW)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .step          (step),
        .load_wr       (load_wr),
        .load_val      (bus_wdata),
        .ctrl_wr       (ctrl_wr),
        .mode_en       (ctrl_q.enable),
        .mode_oneshot  (ctrl_q.oneshot),
        .mode_periodic (ctrl_q.periodic),
        .mode_wide     (ctrl_q.wide),
        .nxt_en        (ctrl_d.enable),
        .nxt_oneshot   (ctrl_d.oneshot),
        .nxt_wide      (ctrl_d.wide),
        .limit         (limit),
        .count         (count),
        .expire        (expire),
        .running       (running)
    );

    AST_IRQ_OFF_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.irq_en |-> !irq); // R10

endmodule

// File: tb/countdown_timer_test.sv
module countdown_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 3'(a); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 3'(a);
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic expect_reg(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, $sformatf("offset %0d", a), v, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1", 2, 32'h20);
        expect_reg("R1", 1, 32'hFFFF_FFFF);
        expect_reg("R1", 4, 32'h0);
        chk("R1", "irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_load_idle;
        wr(0, 32'd5);
        expect_reg("R2", 1, 32'd5);
        expect_reg("R2", 0, 32'd5);
        expect_reg("R2", 6, 32'd5);
        ticks(4);
        expect_reg("R5", 1, 32'd5);
        wr(1, 32'd99);
        expect_reg("R12", 1, 32'd5);
        expect_reg("R12", 0, 32'd5);
    endtask

    task automatic t_periodic;
        wr(2, 32'hE2);
        expect_reg("R12", 2, 32'hE2);
        ticks(4);
        expect_reg("R6", 1, 32'd1);
        expect_reg("R6", 4, 32'd0);
        ticks(1);
        expect_reg("R6", 1, 32'd5);
        expect_reg("R10", 4, 32'd1);
        expect_reg("R10", 5, 32'd1);
        chk("R10", "irq", {31'd0, irq}, 32'd1);
        wr(3, 32'd0);
        expect_reg("R11", 4, 32'd0);
        wr(6, 32'd9);
        expect_reg("R3", 1, 32'd5);
        expect_reg("R3", 0, 32'd9);
        ticks(5);
        expect_reg("R6", 1, 32'd9);
        wr(3, 32'd0);
    endtask

    task automatic t_mask;
        wr(2, 32'hC2);
        ticks(9);
        expect_reg("R10", 4, 32'd1);
        expect_reg("R10", 5, 32'd0);
        chk("R10", "irq masked", {31'd0, irq}, 32'd0);
        wr(3, 32'd0);
    endtask

    task automatic t_free;
        wr(2, 32'h80);
        wr(0, 32'd3);
        ticks(3);
        expect_reg("R7", 1, 32'h0000_FFFF);
        expect_reg("R7", 4, 32'd1);
        wr(3, 32'd0);
        wr(2, 32'h82);
        wr(0, 32'd2);
        ticks(2);
        expect_reg("R7", 1, 32'hFFFF_FFFF);
        wr(3, 32'd0);
    endtask

    task automatic t_narrow;
        wr(2, 32'hC0);
        wr(0, 32'h0001_0005);
        ticks(1);
        expect_reg("R9", 1, 32'h0001_0004);
        ticks(4);
        expect_reg("R9", 1, 32'h0000_0005);
        wr(3, 32'd0);
    endtask

    task automatic t_oneshot;
        wr(2, 32'h81);
        wr(0, 32'd2);
        ticks(2);
        expect_reg("R8", 1, 32'd0);
        expect_reg("R8", 4, 32'd1);
        wr(3, 32'd0);
        ticks(5);
        expect_reg("R8", 1, 32'd0);
        expect_reg("R8", 4, 32'd0);
        wr(0, 32'd0);
        ticks(3);
        expect_reg("R8", 4, 32'd0);
    endtask

    task automatic t_prescale;
        wr(2, 32'h86);
        wr(0, 32'd10);
        ticks(15);
        expect_reg("R4", 1, 32'd10);
        ticks(1);
        expect_reg("R4", 1, 32'd9);
        wr(2, 32'h8A);
        ticks(255);
        expect_reg("R4", 1, 32'd9);
        ticks(1);
        expect_reg("R4", 1, 32'd8);
        wr(2, 32'h86);
        ticks(8);
        wr(0, 32'd10);
        ticks(15);
        expect_reg("R4", 1, 32'd10);
        ticks(1);
        expect_reg("R4", 1, 32'd9);
        wr(2, 32'h8E);
        ticks(1);
        expect_reg("R4", 1, 32'd8);
    endtask

    task automatic t_collide;
        wr(2, 32'hE2);
        wr(0, 32'd3);
        wr(3, 32'd0);
        ticks(2);
        expect_reg("R11", 1, 32'd1);
        @(negedge clk);
        tick_en = 1'b1; bus_addr = 3'd3; bus_we = 1'b1; bus_wdata = 32'd0;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        expect_reg("R11", 4, 32'd1);
        expect_reg("R11", 1, 32'd3);
        wr(3, 32'd0);
        expect_reg("R11", 4, 32'd0);
    endtask

    task automatic t_unused;
        expect_reg("R13", 3, 32'd0);
        expect_reg("R13", 7, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_idle();
        t_periodic();
        t_mask();
        t_free();
        t_narrow();
        t_oneshot();
        t_prescale();
        t_collide();
        t_unused();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule